// File: doc/BRIEF.md
# Endpoint Buffer Ownership Controller

This block keeps the bookkeeping for a set of USB device endpoints. For each endpoint it records which packet buffers hold valid data, which buffer the CPU is working on, which buffer the serial side uses next, the data toggle, and whether the endpoint is halted. Packet data, the serial engine and interrupts live elsewhere. The block only decides ownership and the handshake answer.

The CPU talks to it through 8-bit command codes. The low nibble of every code is the endpoint slot: slot 0 is control OUT, slot 1 is control IN, and slots 2 to 15 are the numbered endpoints. A validate command hands a filled IN buffer to the USB side. A clear command gives an emptied OUT buffer back to the USB side. A status command returns a snapshot byte and changes nothing. The serial side posts one event per cycle: IN token, OUT packet complete, SETUP packet, or stall request. One cycle later it gets back ACK, NAK or STALL.

Each slot is either single- or double-buffered, and either IN or OUT, as set by parameter masks. The two control slots are single-buffered.

Top module: `epbuf_ctrl`

## Requirements
- R1: A validate code 0x61–0x6F (slot = low nibble; 0x60 is not a command) sets the full flag of the CPU-side buffer of an IN slot. The same code sent to an OUT slot changes nothing.
- R2: A clear code 0x70 or 0x72–0x7F (slot = low nibble) clears the full flag of the CPU-side buffer of an OUT slot. On slot 0 it also clears the setup and overwrite bits. Code 0x71, and any clear code sent to an IN slot, changes nothing.
- R3: A status code 0xD0–0xDF returns one byte in the next cycle with cpu_rd_valid high. The byte layout is: bit7 stalled, bit6 second buffer full, bit5 first buffer full, bit4 next data toggle (1 = DATA1), bit3 overwrite, bit2 setup seen, bit1 CPU-side buffer index, bit0 always 0. Reading is non-destructive.
- R4: On a double-buffered slot, every validate (IN) or clear (OUT) toggles the CPU-side buffer index. On a single-buffered slot, that index stays 0 and only the first full flag is used.
- R5: An IN token on an IN slot answers NAK if the USB-side buffer is empty. If that buffer is full, the answer is ACK, the flag is cleared, the toggle flips, and on a double-buffered slot the USB-side index advances.
- R6: An OUT-complete event on an OUT slot answers ACK if the USB-side buffer is empty. It then sets the flag, flips the toggle, and advances the USB-side index on a double-buffered slot. If that buffer is full, the answer is NAK and no state changes.
- R7: A stall event sets the stall bit and is answered STALL. A stalled slot answers STALL to IN tokens and OUT packets, and no other state changes.
- R8: A SETUP event on slot 0 is always answered ACK. It sets the setup bit and the full flag, and sets the overwrite bit if the buffer was already full. It also clears the stall bit of slots 0 and 1. A SETUP event on any other slot answers NAK and changes nothing.
- R9: Every event answer appears exactly one cycle after the event with usb_rsp_valid high, and only then. The answer codes are NAK=0, ACK=1, STALL=2.
- R10: After reset, both valid outputs are low and every status byte reads 0x00.
- R11: An IN token on an OUT slot, or an OUT-complete event on an IN slot, answers NAK and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cmd_valid | input | 1 | Command strobe |
| cpu_cmd | input | 8 | Command code |
| cpu_rd_valid | output | 1 | Status byte valid |
| cpu_rd_data | output | 8 | Status byte |
| usb_evt_valid | input | 1 | Serial-side event strobe |
| usb_evt_type | input | 2 | 0 IN token, 1 OUT complete, 2 SETUP, 3 stall |
| usb_evt_ep | input | 4 | Event slot |
| usb_rsp_valid | output | 1 | Answer valid |
| usb_rsp | output | 2 | Answer: 0 NAK, 1 ACK, 2 STALL |

## Verification
Every one of the sixteen slots is driven through a fixed script. The script fills a slot past capacity and then drains it past empty, so that single and double buffering differ in how many ACKs come before the first NAK, and in how the CPU index bit moves. Wrong-direction tokens and wrong-direction commands, plus the two non-commands 0x60 and 0x71, are each followed by a status read, which shows that no state was touched. A stall is then applied to every slot, followed by IN and OUT traffic. Repeated SETUP packets on slot 0 separate the overwrite case from the first-arrival case, and show that the stall is lifted on both control slots.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
   typedef enum logic [1:0] {
      EV_IN_TOKEN = 2'd0,
      EV_OUT_DONE = 2'd1,
      EV_SETUP    = 2'd2,
      EV_STALL    = 2'd3
   } usb_evt_e;

   typedef enum logic [1:0] {
      RSP_NAK   = 2'd0,
      RSP_ACK   = 2'd1,
      RSP_STALL = 2'd2
   } usb_rsp_e;

   localparam logic [3:0] GRP_VALIDATE = 4'h6;
   localparam logic [3:0] GRP_CLEAR    = 4'h7;
   localparam logic [3:0] GRP_STATUS   = 4'hD;
   localparam int unsigned MAX_SLOTS   = 16;
endpackage

// File: rtl/epbuf_cmd_dec.sv
module epbuf_cmd_dec
   import epbuf_pkg::*;
#(
   parameter int unsigned NUM_EP = 16
) (
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   output logic [NUM_EP-1:0] val_oh,
   output logic [NUM_EP-1:0] clr_oh,
   output logic              sts_hit,
   output logic [3:0]        sts_idx
);
   localparam logic [4:0] NUM_EP_W = 5'(NUM_EP);

   logic [3:0] grp;
   logic [3:0] slot;
   logic       is_val;
   logic       is_clr;

   assign grp    = cmd_code[7:4];
   assign slot   = cmd_code[3:0];
   // slot 0 has no validate code, slot 1 has no clear code
   assign is_val = cmd_valid && (grp == GRP_VALIDATE) && (slot != 4'd0);
   assign is_clr = cmd_valid && (grp == GRP_CLEAR) && (slot != 4'd1);

   assign sts_hit = cmd_valid && (grp == GRP_STATUS) && ({1'b0, slot} < NUM_EP_W);
   assign sts_idx = slot;

   for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
      assign val_oh[i] = is_val && (slot == 4'(i));
      assign clr_oh[i] = is_clr && (slot == 4'(i));
   end
endmodule

// File: rtl/epbuf_ep_slot.sv
module epbuf_ep_slot
   import epbuf_pkg::*;
#(
   parameter bit IS_IN       = 1'b0,
   parameter bit IS_DBL      = 1'b0,
   parameter bit IS_CTRL_OUT = 1'b0,
   parameter bit IS_CTRL     = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_validate,
   input  logic       cpu_clear,
   input  logic       ev_hit,
   input  logic [1:0] ev_type,
   input  logic       ctrl_setup,
   output logic [7:0] status,
   output logic [1:0] rsp
);
   localparam logic [1:0] BUF_MASK = IS_DBL ? 2'b11 : 2'b01;

   logic [1:0] full_q;
   logic       cptr_q, uptr_q;
   logic       pid_q, stall_q, ovw_q, setup_q;

   logic [1:0] set_m, clr_m;
   logic       adv_u, adv_c, tgl_pid;
   logic       stall_set, stall_clr, ovw_set, setup_set, flags_clr;
   logic       usb_full;

   assign usb_full = full_q[uptr_q];

   always_comb begin
      set_m     = 2'b00;
      clr_m     = 2'b00;
      adv_u     = 1'b0;
      adv_c     = 1'b0;
      tgl_pid   = 1'b0;
      stall_set = 1'b0;
      ovw_set   = 1'b0;
      setup_set = 1'b0;
      flags_clr = 1'b0;
      rsp       = RSP_NAK;
      if (ev_hit) begin
         case (ev_type)
            EV_IN_TOKEN: begin
               if (IS_IN) begin
                  if (stall_q) begin
                     rsp = RSP_STALL;
                  end else if (usb_full) begin
                     rsp           = RSP_ACK;
                     clr_m[uptr_q] = 1'b1;
                     adv_u         = 1'b1;
                     tgl_pid       = 1'b1;
                  end
               end
            end
            EV_OUT_DONE: begin
               if (!IS_IN) begin
                  if (stall_q) begin
                     rsp = RSP_STALL;
                  end else if (!usb_full) begin
                     rsp           = RSP_ACK;
                     set_m[uptr_q] = 1'b1;
                     adv_u         = 1'b1;
                     tgl_pid       = 1'b1;
                  end
               end
            end
            EV_SETUP: begin
               if (IS_CTRL_OUT) begin
                  rsp           = RSP_ACK;
                  setup_set     = 1'b1;
                  ovw_set       = usb_full;
                  set_m[uptr_q] = 1'b1;
               end
            end
            default: begin
               rsp       = RSP_STALL;
               stall_set = 1'b1;
            end
         endcase
      end
      if (cpu_validate && IS_IN) begin
         set_m[cptr_q] = 1'b1;
         adv_c         = 1'b1;
      end
      if (cpu_clear && !IS_IN) begin
         clr_m[cptr_q] = 1'b1;
         adv_c         = 1'b1;
         flags_clr     = IS_CTRL_OUT;
      end
   end

   assign stall_clr = IS_CTRL && ctrl_setup;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 2'b00;
         cptr_q  <= 1'b0;
         uptr_q  <= 1'b0;
         pid_q   <= 1'b0;
         stall_q <= 1'b0;
         ovw_q   <= 1'b0;
         setup_q <= 1'b0;
      end else begin
         full_q  <= ((full_q & ~clr_m) | set_m) & BUF_MASK;
         cptr_q  <= cptr_q ^ (adv_c & IS_DBL);
         uptr_q  <= uptr_q ^ (adv_u & IS_DBL);
         pid_q   <= pid_q ^ tgl_pid;
         stall_q <= stall_set | (stall_q & ~stall_clr);
         ovw_q   <= ovw_set | (ovw_q & ~flags_clr);
         setup_q <= setup_set | (setup_q & ~flags_clr);
      end
   end

   assign status = {stall_q, full_q[1], full_q[0], pid_q, ovw_q, setup_q, cptr_q, 1'b0};
endmodule

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
   import epbuf_pkg::*;
#(
   parameter int unsigned NUM_EP = 16,
   parameter logic [15:0] EP_IN  = 16'hAAAA,
   parameter logic [15:0] EP_DBL = 16'hFFF0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_cmd_valid,
   input  logic [7:0] cpu_cmd,
   output logic       cpu_rd_valid,
   output logic [7:0] cpu_rd_data,
   input  logic       usb_evt_valid,
   input  logic [1:0] usb_evt_type,
   input  logic [3:0] usb_evt_ep,
   output logic       usb_rsp_valid,
   output logic [1:0] usb_rsp
);
   localparam logic [4:0] NUM_EP_W = 5'(NUM_EP);

   if (NUM_EP < 2 || NUM_EP > MAX_SLOTS) begin : g_bad_count
      $error("epbuf_ctrl: NUM_EP must lie in 2..16");
   end
   if (EP_IN[0] || !EP_IN[1]) begin : g_bad_dir
      $error("epbuf_ctrl: slot 0 must be OUT and slot 1 must be IN");
   end
   if (EP_DBL[1:0] != 2'b00) begin : g_bad_ctrl
      $error("epbuf_ctrl: control slots must be single-buffered");
   end

   logic [NUM_EP-1:0] val_oh, clr_oh;
   logic              sts_hit;
   logic [3:0]        sts_idx;
   logic              ep_ok;
   logic              ctrl_setup;
   logic [7:0]        status_arr [NUM_EP];
   logic [1:0]        rsp_arr    [NUM_EP];

   epbuf_cmd_dec #(.NUM_EP(NUM_EP)) u_dec (
      .cmd_valid (cpu_cmd_valid),
      .cmd_code  (cpu_cmd),
      .val_oh    (val_oh),
      .clr_oh    (clr_oh),
      .sts_hit   (sts_hit),
      .sts_idx   (sts_idx)
   );

   assign ep_ok      = usb_evt_valid && ({1'b0, usb_evt_ep} < NUM_EP_W);
   assign ctrl_setup = usb_evt_valid && (usb_evt_type == EV_SETUP) && (usb_evt_ep == 4'd0);

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      epbuf_ep_slot #(
         .IS_IN       (EP_IN[i]),
         .IS_DBL      (EP_DBL[i]),
         .IS_CTRL_OUT (i == 0),
         .IS_CTRL     (i < 2)
      ) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .cpu_validate (val_oh[i]),
         .cpu_clear    (clr_oh[i]),
         .ev_hit       (ep_ok && (usb_evt_ep == 4'(i))),
         .ev_type      (usb_evt_type),
         .ctrl_setup   (ctrl_setup),
         .status       (status_arr[i]),
         .rsp          (rsp_arr[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_rd_valid  <= 1'b0;
         cpu_rd_data   <= 8'h00;
         usb_rsp_valid <= 1'b0;
         usb_rsp       <= RSP_NAK;
      end else begin
         cpu_rd_valid  <= sts_hit;
         if (sts_hit) cpu_rd_data <= status_arr[sts_idx];
         usb_rsp_valid <= ep_ok;
         if (ep_ok) usb_rsp <= rsp_arr[usb_evt_ep];
      end
   end
endmodule

// File: rtl/epbuf_ctrl_chk.sv
module epbuf_ctrl_chk #(
   parameter int unsigned NUM_EP = 16,
   parameter logic [15:0] EP_DBL = 16'hFFF0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_cmd_valid,
   input logic [7:0] cpu_cmd,
   input logic       cpu_rd_valid,
   input logic [7:0] cpu_rd_data,
   input logic       usb_evt_valid,
   input logic [1:0] usb_evt_type,
   input logic [3:0] usb_evt_ep,
   input logic       usb_rsp_valid,
   input logic [1:0] usb_rsp
);
   p_rsp_follows_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      usb_rsp_valid |-> $past(usb_evt_valid));

   p_rsp_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      usb_rsp_valid |-> (usb_rsp != 2'd3));

   p_stall_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_evt_valid && usb_evt_type == 2'd3 && {1'b0, usb_evt_ep} < 5'(NUM_EP))
      |=> (usb_rsp_valid && usb_rsp == 2'd2));

   p_setup_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_evt_valid && usb_evt_type == 2'd2 && usb_evt_ep == 4'd0)
      |=> (usb_rsp_valid && usb_rsp == 2'd1));

   p_rd_follows_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd_valid |-> $past(cpu_cmd_valid && cpu_cmd[7:4] == 4'hD));

   p_bit0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd_valid |-> !cpu_rd_data[0]);

   p_single_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_valid && !EP_DBL[$past(cpu_cmd[3:0])]) |-> (!cpu_rd_data[6] && !cpu_rd_data[1]));
endmodule

bind epbuf_ctrl epbuf_ctrl_chk #(.NUM_EP(NUM_EP), .EP_DBL(EP_DBL)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_cmd_valid (cpu_cmd_valid),
   .cpu_cmd       (cpu_cmd),
   .cpu_rd_valid  (cpu_rd_valid),
   .cpu_rd_data   (cpu_rd_data),
   .usb_evt_valid (usb_evt_valid),
   .usb_evt_type  (usb_evt_type),
   .usb_evt_ep    (usb_evt_ep),
   .usb_rsp_valid (usb_rsp_valid),
   .usb_rsp       (usb_rsp)
);

// File: tb/epbuf_ctrl_tb.sv
module epbuf_ctrl_tb;
   localparam logic [15:0] IN_M = 16'hAAAA;
   localparam logic [15:0] DB_M = 16'hFFF0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_cmd_valid = 1'b0;
   logic [7:0] cpu_cmd = 8'h00;
   logic       cpu_rd_valid;
   logic [7:0] cpu_rd_data;
   logic       usb_evt_valid = 1'b0;
   logic [1:0] usb_evt_type = 2'd0;
   logic [3:0] usb_evt_ep = 4'd0;
   logic       usb_rsp_valid;
   logic [1:0] usb_rsp;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [1:0] mf [16];
   bit mc [16], mu [16], mp [16], ms [16], mo [16], mset [16];

   always #4 clk = ~clk;

   epbuf_ctrl #(.NUM_EP(16), .EP_IN(IN_M), .EP_DBL(DB_M)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_cmd_valid(cpu_cmd_valid), .cpu_cmd(cpu_cmd),
      .cpu_rd_valid(cpu_rd_valid), .cpu_rd_data(cpu_rd_data),
      .usb_evt_valid(usb_evt_valid), .usb_evt_type(usb_evt_type), .usb_evt_ep(usb_evt_ep),
      .usb_rsp_valid(usb_rsp_valid), .usb_rsp(usb_rsp)
   );

   function automatic logic [7:0] exp_sts(int i);
      return {ms[i], mf[i][1], mf[i][0], mp[i], mo[i], mset[i], mc[i], 1'b0};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic read_sts(int i, string tag);
      @(negedge clk);
      cpu_cmd_valid = 1'b1;
      cpu_cmd = 8'hD0 | 8'(i);
      @(negedge clk);
      cpu_cmd_valid = 1'b0;
      check({tag, " R3 rd_valid"}, 32'(cpu_rd_valid), 32'd1);
      check({tag, " R3 status byte"}, 32'(cpu_rd_data), 32'(exp_sts(i)));
   endtask

   task automatic do_cmd(logic [7:0] code, string tag);
      int s;
      s = int'(code[3:0]);
      if (code[7:4] == 4'h6 && s != 0 && IN_M[s]) begin
         mf[s][mc[s]] = 1'b1;
         if (DB_M[s]) mc[s] = ~mc[s];
      end
      if (code[7:4] == 4'h7 && s != 1 && !IN_M[s]) begin
         mf[s][mc[s]] = 1'b0;
         if (DB_M[s]) mc[s] = ~mc[s];
         if (s == 0) begin mo[0] = 1'b0; mset[0] = 1'b0; end
      end
      @(negedge clk);
      cpu_cmd_valid = 1'b1;
      cpu_cmd = code;
      @(negedge clk);
      cpu_cmd_valid = 1'b0;
      check({tag, " no status strobe"}, 32'(cpu_rd_valid), 32'd0);
      read_sts(s, tag);
   endtask

   task automatic evt(int t, int i, string tag);
      logic [1:0] exp;
      exp = 2'd0;
      case (t)
         0: if (IN_M[i]) begin
               if (ms[i]) exp = 2'd2;
               else if (mf[i][mu[i]]) begin
                  exp = 2'd1; mf[i][mu[i]] = 1'b0; mp[i] = ~mp[i];
                  if (DB_M[i]) mu[i] = ~mu[i];
               end
            end
         1: if (!IN_M[i]) begin
               if (ms[i]) exp = 2'd2;
               else if (!mf[i][mu[i]]) begin
                  exp = 2'd1; mf[i][mu[i]] = 1'b1; mp[i] = ~mp[i];
                  if (DB_M[i]) mu[i] = ~mu[i];
               end
            end
         2: if (i == 0) begin
               exp = 2'd1; mo[0] = mo[0] | mf[0][0]; mset[0] = 1'b1;
               mf[0][0] = 1'b1; ms[0] = 1'b0; ms[1] = 1'b0;
            end
         default: begin exp = 2'd2; ms[i] = 1'b1; end
      endcase
      @(negedge clk);
      usb_evt_valid = 1'b1;
      usb_evt_type = 2'(t);
      usb_evt_ep = 4'(i);
      @(negedge clk);
      usb_evt_valid = 1'b0;
      check({tag, " R9 rsp_valid"}, 32'(usb_rsp_valid), 32'd1);
      check({tag, " answer"}, 32'(usb_rsp), 32'(exp));
      @(negedge clk);
      check({tag, " R9 single answer"}, 32'(usb_rsp_valid), 32'd0);
      read_sts(i, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         mf[i] = 2'b00; mc[i] = 0; mu[i] = 0; mp[i] = 0; ms[i] = 0; mo[i] = 0; mset[i] = 0;
      end
      repeat (3) @(negedge clk);
      check("R10 rd_valid in reset", 32'(cpu_rd_valid), 32'd0);
      check("R10 rsp_valid in reset", 32'(usb_rsp_valid), 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) read_sts(i, "R10 reset status");
      read_sts(5, "R3 repeated read unchanged");

      do_cmd(8'h60, "R1 code 0x60 ignored");
      read_sts(1, "R1 control IN after 0x60");
      do_cmd(8'h71, "R2 code 0x71 ignored");

      for (int i = 0; i < 16; i++) begin
         if (IN_M[i]) begin
            evt(0, i, "R5 IN token on empty");
            do_cmd(8'h60 | 8'(i), "R1 validate");
            evt(1, i, "R11 OUT on IN slot");
            do_cmd(8'h70 | 8'(i), "R2 clear on IN slot ignored");
            do_cmd(8'h60 | 8'(i), "R4 second validate");
            evt(0, i, "R5 IN token drain 1");
            evt(0, i, "R5 IN token drain 2");
            evt(0, i, "R5 IN token drain 3");
         end else begin
            evt(1, i, "R6 OUT fill 1");
            evt(1, i, "R6 OUT fill 2");
            evt(1, i, "R6 OUT fill 3");
            evt(0, i, "R11 IN token on OUT slot");
            if (i != 0) do_cmd(8'h60 | 8'(i), "R1 validate on OUT slot ignored");
            do_cmd(8'h70 | 8'(i), "R2 clear 1");
            do_cmd(8'h70 | 8'(i), "R4 clear 2");
            evt(1, i, "R6 OUT after clear");
         end
         evt(3, i, "R7 stall request");
         evt(0, i, "R7 IN while stalled");
         evt(1, i, "R7 OUT while stalled");
      end

      evt(2, 3, "R8 SETUP on non-control slot");
      evt(2, 0, "R8 SETUP while full");
      evt(2, 0, "R8 SETUP repeat");
      read_sts(1, "R8 control IN stall lifted");
      do_cmd(8'h70, "R2 clear control OUT flags");
      evt(2, 0, "R8 SETUP on empty");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule